// File: doc/BRIEF.md
# Masked Register-List Transfer Sequencer

This block turns one decoded masked load-multiple or store-multiple operation into a series of single-register memory transfers. It receives a register-selection mask, a base word address, a starting register index and a direction bit. It then drives a request/acknowledge memory port with one register index and one address per transfer.

The starting register is always transferred first. After that, the mask is consumed from its low end. Each set bit at mask position i selects register start+i. Clear bits skip registers without using up an address slot, so the selected registers land in consecutive 8-byte words. A trailing-zero encoder jumps over any run of clear bits in a single cycle.

When the work ends, the block pulses `done` and presents the address of the last transfer for base-register write-back. It also flags an error if a selected register would lie beyond the last register. While a sequence runs, the remaining mask, the current register and the current address are visible, so a precise exception can resume the operation mid-way.

Top module: `mask_xfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `err` are all low.
- R2: The first transfer uses `start_reg` at `base_addr`, whatever the value of `mask_in[0]`.
- R3: Each later transfer uses register `start_reg + i` for each set bit i ≥ 1 of `mask_in`, in ascending order of i. Clear bits produce no transfer.
- R4: Consecutive transfers of one sequence use addresses that increase by exactly 8 (one word). Skipped registers take no address.
- R5: With no overflow, the number of transfers is the count of set bits in `mask_in[31:1]` plus one.
- R6: One cycle after the last transfer's acknowledge, `done` is high for exactly one cycle and `busy` is low. In that cycle `final_addr` holds the address of the last transfer made.
- R7: `mem_we` is 1 for every transfer of a store (`is_load`=0) and 0 for every transfer of a load. Both directions walk registers and addresses identically.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_reg`, `mem_addr` and `mem_we` hold their values and `mem_req` stays high.
- R9: If the next selected register index would exceed 63, the sequence ends after the current transfer. In that case `err` is high together with `done`; in every other case `err` is low.
- R10: During each transfer, `rs_reg` and `rs_addr` equal that transfer's register and address, and `rs_mask` equals `mask_in >> (rs_reg - start_reg)`.
- R11: A `start` pulse while `busy` is high is ignored; the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| is_load | input | 1 | 1 = load-multiple, 0 = store-multiple |
| mask_in | input | 32 | Register-selection mask |
| base_addr | input | 32 | Byte address of the first transfer |
| start_reg | input | 6 | Index of the first register |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write register to memory, 0 = read into register |
| mem_addr | output | 32 | Transfer address |
| mem_reg | output | 6 | Register index of the transfer |
| mem_ack | input | 1 | Transfer accepted |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Register index overflow; valid with done |
| final_addr | output | 32 | Address of the last transfer, valid with done |
| rs_mask | output | 32 | Remaining mask; bit 0 is the current register |
| rs_reg | output | 6 | Current register index for resume |
| rs_addr | output | 32 | Current address for resume |

## Verification
The walk is tried with sparse masks, with masks that differ only in bit 0, with all-zero and single-bit masks, and with a fully set mask. Together these show that the low bit is forced and that clear bits skip registers but not addresses, and they cover the one-transfer case. Masks whose top bit sits far from the starting register, and start indices near 63, tell a clean finish at register 63 apart from an overflow stop. Vectors with and without acknowledge stalls check that the request holds steady. Store and load vectors show that only the write-enable differs between the two directions.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
   typedef enum logic {
      MXS_IDLE = 1'b0,
      MXS_RUN  = 1'b1
   } mxs_state_e;
endpackage

// File: rtl/mxs_tzc.sv
// Trailing-zero counter: index of the lowest set bit of vec (0 when vec is 0).
module mxs_tzc #(
   parameter int W  = 32,
   localparam int CW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [W-1:0] below;
   logic [W-1:0] lowest;

   assign below[0] = 1'b0;
   genvar gi;
   generate
      for (gi = 1; gi < W; gi++) begin : g_prefix
         assign below[gi] = below[gi-1] | vec[gi-1];
      end
      for (gi = 0; gi < W; gi++) begin : g_low
         assign lowest[gi] = vec[gi] & ~below[gi];
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         if (lowest[i]) cnt = cnt | CW'(i);
      end
   end

   always_comb begin
      if (vec != '0) begin
         a_r3_one_lowest: assert ($onehot0(lowest) && lowest != '0);
      end
   end
endmodule

// File: rtl/mxs_step.sv
// Computes the state of the following transfer from the current one.
module mxs_step #(
   parameter int MASK_W     = 32,
   parameter int REG_IDX_W  = 6,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 8,
   parameter int NUM_REGS   = 64,
   localparam int CW    = $clog2(MASK_W),
   localparam int SUM_W = REG_IDX_W + CW + 2
) (
   input  logic [MASK_W-1:0]    cur_mask,
   input  logic [REG_IDX_W-1:0] cur_reg,
   input  logic [ADDR_W-1:0]    cur_addr,
   output logic [MASK_W-1:0]    nxt_mask,
   output logic [REG_IDX_W-1:0] nxt_reg,
   output logic [ADDR_W-1:0]    nxt_addr,
   output logic                 last,
   output logic                 ovf
);
   localparam logic [SUM_W-1:0] TOP_REG = SUM_W'(NUM_REGS - 1);

   logic [MASK_W-1:0] shifted;
   logic [CW-1:0]     tz;
   logic [SUM_W-1:0]  sum;

   assign shifted = cur_mask >> 1;

   mxs_tzc #(.W(MASK_W)) u_tzc (
      .vec (shifted),
      .cnt (tz)
   );

   assign sum      = SUM_W'(cur_reg) + SUM_W'(tz) + SUM_W'(1);
   assign last     = (shifted == '0);
   assign ovf      = !last && (sum > TOP_REG);
   assign nxt_mask = shifted >> tz;
   assign nxt_reg  = sum[REG_IDX_W-1:0];
   assign nxt_addr = cur_addr + ADDR_W'(WORD_BYTES);

   always_comb begin
      if (!last) begin
         a_r3_jump_hits_set_bit: assert (nxt_mask[0]);
      end
   end
endmodule

// File: rtl/mask_xfer_seq.sv
module mask_xfer_seq
   import mxs_pkg::*;
#(
   parameter int MASK_W     = 32,
   parameter int REG_IDX_W  = 6,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 8,
   parameter int NUM_REGS   = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 is_load,
   input  logic [MASK_W-1:0]    mask_in,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [REG_IDX_W-1:0] start_reg,
   output logic                 busy,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [REG_IDX_W-1:0] mem_reg,
   input  logic                 mem_ack,
   output logic                 done,
   output logic                 err,
   output logic [ADDR_W-1:0]    final_addr,
   output logic [MASK_W-1:0]    rs_mask,
   output logic [REG_IDX_W-1:0] rs_reg,
   output logic [ADDR_W-1:0]    rs_addr
);
   generate
      if (MASK_W < 2) begin : g_bad_mask
         $error("MASK_W must be at least 2");
      end
      if (NUM_REGS > (1 << REG_IDX_W) || NUM_REGS < 1) begin : g_bad_regs
         $error("NUM_REGS must fit in REG_IDX_W bits");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
   endgenerate

   mxs_state_e           st_q;
   logic [MASK_W-1:0]    mask_q;
   logic [REG_IDX_W-1:0] reg_q;
   logic [ADDR_W-1:0]    addr_q;
   logic                 we_q;
   logic                 done_q;
   logic                 err_q;
   logic [ADDR_W-1:0]    fin_q;

   logic [MASK_W-1:0]    nxt_mask;
   logic [REG_IDX_W-1:0] nxt_reg;
   logic [ADDR_W-1:0]    nxt_addr;
   logic                 last;
   logic                 ovf;

   mxs_step #(
      .MASK_W     (MASK_W),
      .REG_IDX_W  (REG_IDX_W),
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES),
      .NUM_REGS   (NUM_REGS)
   ) u_step (
      .cur_mask (mask_q),
      .cur_reg  (reg_q),
      .cur_addr (addr_q),
      .nxt_mask (nxt_mask),
      .nxt_reg  (nxt_reg),
      .nxt_addr (nxt_addr),
      .last     (last),
      .ovf      (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= MXS_IDLE;
         mask_q <= '0;
         reg_q  <= '0;
         addr_q <= '0;
         we_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         fin_q  <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            MXS_IDLE: begin
               if (start) begin
                  st_q   <= MXS_RUN;
                  mask_q <= mask_in;
                  reg_q  <= start_reg;
                  addr_q <= base_addr;
                  we_q   <= ~is_load;
               end
            end
            MXS_RUN: begin
               if (mem_ack) begin
                  if (last || ovf) begin
                     st_q   <= MXS_IDLE;
                     done_q <= 1'b1;
                     err_q  <= ovf;
                     fin_q  <= addr_q;
                  end else begin
                     mask_q <= nxt_mask;
                     reg_q  <= nxt_reg;
                     addr_q <= nxt_addr;
                  end
               end
            end
            default: st_q <= MXS_IDLE;
         endcase
      end
   end

   assign busy       = (st_q == MXS_RUN);
   assign mem_req    = busy;
   assign mem_we     = we_q;
   assign mem_addr   = addr_q;
   assign mem_reg    = reg_q;
   assign done       = done_q;
   assign err        = err_q;
   assign final_addr = fin_q;
   assign rs_mask    = mask_q;
   assign rs_reg     = reg_q;
   assign rs_addr    = addr_q;

   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

   a_r3_reg_ascends: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (!mem_req || mem_reg > $past(mem_reg)));

   a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_we)));

   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(mem_req) && $past(mem_ack) && !busy));

   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
endmodule

// File: tb/mask_xfer_seq_bench.sv
module mask_xfer_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_load = 1'b0;
   logic [31:0] mask_in = '0;
   logic [31:0] base_addr = '0;
   logic [5:0]  start_reg = '0;
   logic        busy, mem_req, mem_we, done, err;
   logic [31:0] mem_addr, final_addr, rs_mask, rs_addr;
   logic [5:0]  mem_reg, rs_reg;
   logic        mem_ack = 1'b0;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   mask_xfer_seq u_mask_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
      .mask_in(mask_in), .base_addr(base_addr), .start_reg(start_reg),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_reg(mem_reg), .mem_ack(mem_ack), .done(done), .err(err),
      .final_addr(final_addr), .rs_mask(rs_mask), .rs_reg(rs_reg), .rs_addr(rs_addr)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, got cycle %0d expected < 50000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // stimulus table: mask, start register, base address, load, stall, poke start mid-run
   localparam int NV = 11;
   localparam logic [31:0] V_MASK [NV] = '{32'h0000_000A, 32'h0000_000B, 32'h0000_0000,
      32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0001, 32'h8000_0000, 32'h0000_0006,
      32'h0000_0002, 32'h00F0_F00C, 32'h0000_0015};
   localparam logic [5:0] V_REG [NV] = '{6'd16, 6'd16, 6'd5, 6'd5, 6'd0, 6'd10,
      6'd40, 6'd62, 6'd62, 6'd3, 6'd20};
   localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3008, 32'h4000,
      32'h5000, 32'h6000, 32'h7000, 32'h8000, 32'h9000, 32'hA000, 32'hB000};
   localparam logic V_LOAD  [NV] = '{0, 1, 0, 1, 1, 0, 1, 0, 1, 1, 0};
   localparam logic V_STALL [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 0, 1, 1};
   localparam logic V_POKE  [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1};

   task automatic run_vec(input logic [31:0] m, input logic [5:0] sr, input logic [31:0] ba,
                          input logic ld, input logic stall, input logic poke);
      int exp_regs[$];
      int n_exp = 1;
      bit exp_err = 0;
      int idx = 0;
      int waitc = 0;
      bit held = 0;
      logic [5:0] h_reg;
      logic [31:0] h_addr;
      bit finished = 0;
      exp_regs.push_back(int'(sr));
      for (int i = 1; i < 32; i++) begin
         if (m[i]) begin
            if (int'(sr) + i > 63) begin exp_err = 1; break; end
            exp_regs.push_back(int'(sr) + i);
         end
      end
      n_exp = exp_regs.size();

      @(negedge clk);
      start = 1; mask_in = m; start_reg = sr; base_addr = ba; is_load = ld;
      @(negedge clk);
      start = 0;
      for (int t = 0; t < 400 && !finished; t++) begin
         if (poke && idx == 1) begin
            start = 1; mask_in = 32'h5555_5555; start_reg = 6'd1; base_addr = 32'hDEAD_0000; is_load = ~ld;
         end else begin
            start = 0;
         end
         if (done) begin
            mem_ack = 0;
            chk(idx == n_exp, "R5 transfer count", idx, n_exp);
            chk(final_addr == ba + 32'(8 * (n_exp - 1)), "R6 final_addr", final_addr, ba + 32'(8 * (n_exp - 1)));
            chk(!busy, "R6 busy low at done", busy, 0);
            chk(err == exp_err, "R9 err flag", err, exp_err);
            finished = 1;
         end else if (mem_req) begin
            if (held) begin
               chk(mem_reg == h_reg && mem_addr == h_addr, "R8 request held on stall", mem_reg, h_reg);
            end
            if (stall && (waitc % 3) != 2) begin
               mem_ack = 0; held = 1; h_reg = mem_reg; h_addr = mem_addr;
            end else begin
               held = 0;
               if (idx < n_exp) begin
                  chk(mem_reg == 6'(exp_regs[idx]), idx == 0 ? "R2 first register" : "R3 register walk",
                      mem_reg, exp_regs[idx]);
                  chk(mem_addr == ba + 32'(8 * idx), idx == 0 ? "R2 base address" : "R4 address step",
                      mem_addr, ba + 32'(8 * idx));
                  chk(mem_we == ~ld, "R7 write enable", mem_we, ~ld);
                  chk(rs_reg == mem_reg && rs_addr == mem_addr, "R10 resume reg/addr", rs_reg, mem_reg);
                  chk(rs_mask == (m >> (exp_regs[idx] - int'(sr))), "R10 resume mask", rs_mask,
                      m >> (exp_regs[idx] - int'(sr)));
               end else begin
                  chk(0, "R5 extra transfer", idx, n_exp);
               end
               idx++;
               mem_ack = 1;
            end
            waitc++;
         end else begin
            mem_ack = 0;
         end
         @(negedge clk);
      end
      start = 0;
      chk(finished, "R6 done seen", finished, 1);
      chk(!done, "R6 done lasts one cycle", done, 0);
      if (poke) chk(!busy, "R11 mid-run start ignored", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !done && !err, "R1 reset state", {busy, mem_req, done, err}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !mem_req && !done && !err, "R1 idle after reset", {busy, mem_req, done, err}, 0);

      for (int v = 0; v < NV; v++) begin
         run_vec(V_MASK[v], V_REG[v], V_BASE[v], V_LOAD[v], V_STALL[v], V_POKE[v]);
      end

      // directed: reset mid-sequence returns to idle (R1)
      @(negedge clk);
      start = 1; mask_in = 32'hFF; start_reg = 6'd8; base_addr = 32'h100; is_load = 0;
      @(negedge clk);
      start = 0;
      chk(busy && mem_req, "R2 request after start", {busy, mem_req}, 3);
      rst_n = 0;
      @(negedge clk);
      chk(!busy && !mem_req && !done, "R1 reset mid-run", {busy, mem_req, done}, 0);
      rst_n = 1;
      @(negedge clk);
      // directed: R9 overflow at the very first step from register 63
      run_vec(32'h0000_0002, 6'd63, 32'hC000, 1'b0, 1'b0, 1'b0);
      // directed: R2 start at 63 with lsb-only mask finishes cleanly
      run_vec(32'h0000_0001, 6'd63, 32'hD000, 1'b1, 1'b0, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule